// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This unit collects the event pulses of a multi-channel display controller into two 32-bit status words and folds them into one interrupt line. Channel 0 and the controller-wide events (underruns, bus error, read status, command completion and the handshakes described below) land in the primary status word. The channel 0 masks sit in control word A. Start-of-frame, end-of-frame and branch events of channels 1 and up land in the secondary status word. Their masks sit at matching positions in control word C. An accepted event whose mask is clear sets a summary bit and copies that channel's frame ID into a capture register.

The unit also owns the enable handshakes. Software dropping the enable bit raises a quick-disable flag. An end-of-frame tick with the disable-request bit set turns the controller off and raises a last-frame flag. Enabling while the AC-bias count field of control word B is non-zero raises an AC-bias flag. Software clears status by writing ones. An event arriving on the same edge as a clear wins.

The register port is a plain write strobe with address and data, plus a separate read address with a combinational read-data output. Event pulses are one cycle wide and are sampled on every rising clock edge.

Top module: `disp_irq_status`

## Requirements
- R1: After reset every register (control A at address 0, control B at 1, control C at 2, primary status at 3, secondary status at 4, ID capture at 5) reads zero and `irq` is low. Any other address reads zero.
- R2: An accepted channel 0 event, or a controller-wide event, sets one bit of primary status on the next edge. The bits are: start-of-frame 1, bus error 2, underrun ch0 4, underrun ch1 5, output underrun 6, end-of-frame 8, branch 9, read status 11, command 12.
- R3: For channel n from 1 to NCH-1, accepted events set secondary status bits: start-of-frame at n-1, end-of-frame at n+7, branch at n+15.
- R4: A start-of-frame or end-of-frame pulse whose per-channel enable input is low changes no register.
- R5: An accepted start-of-frame, end-of-frame or branch event whose mask is clear sets summary bit 10 and loads the ID capture register with that channel's frame ID. The masks are control A bits 4, 6 and 20 for channel 0, and control C at the secondary status positions for channel n. A masked event sets only its status bit. When several channels hit together, the highest-numbered one is captured.
- R6: A bus-error pulse sets bits 2 and 10, writes `ber_chan` into bits 30:28, and captures the frame ID of that channel, ahead of any other capture on the same edge.
- R7: One edge after the state changes, `irq` is high exactly when some primary status bit is set with its mask clear, or some secondary status bit is set with its control C bit clear. The primary bits and their masks, taken from control A unless stated, are: bit 0 by 3, bit 1 by 4, bit 4 by 5, bit 5 by control C bit 24, bit 6 by 21, bit 7 by 11, bit 8 by 6, bit 9 by 20, bit 11 by 23, bit 12 by 24. Primary bits 2, 3 and 10 never drive `irq`.
- R8: Writing primary status clears each of bits 11:0 whose written bit is 1. Writing a 1 to bit 2 also zeroes bits 30:28. Writing secondary status clears only bits under 0x003E3F3F.
- R9: A status bit set by an event on the same edge as a software clear of that bit reads 1 afterwards.
- R10: A control A write with data bit 0 clear, while control A bit 0 is set, sets primary status bit 7.
- R11: An end-of-frame tick while control A bits 0 and 10 are both set clears control A bit 0 and sets primary status bit 0.
- R12: A control A write with data bit 0 set and data bit 22 clear, while control B bits 19:16 are non-zero, sets primary status bit 3.
- R13: Control writes are masked: control A by 0x07FFFFFF, control B by 0xEFFFFFFF, control C by 0x3F3F3F3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data for `rd_addr`, combinational |
| sof_pulse | input | NCH | Start-of-frame pulse per channel |
| sof_en | input | NCH | Per-channel start-of-frame enable from the command word |
| eof_pulse | input | NCH | End-of-frame pulse per channel |
| eof_en | input | NCH | Per-channel end-of-frame enable from the command word |
| brs_pulse | input | NCH | Branch-taken pulse per channel |
| udr_pulse | input | 2 | Input underrun pulse, channels 0 and 1 |
| ouf_pulse | input | 1 | Output underrun pulse |
| rdst_pulse | input | 1 | Read-status pulse |
| cmd_pulse | input | 1 | Command-done pulse |
| ber_pulse | input | 1 | Bus-error pulse |
| ber_chan | input | 3 | Channel that raised the bus error |
| frame_end | input | 1 | End-of-frame tick for the disable request |
| frame_ids | input | NCH*32 | Frame ID of every channel, channel c at bits 32c+31:32c |
| irq | output | 1 | Registered combined interrupt |

## Verification
The bench builds the unit with NCH = 7, the widest layout the two status words allow. At that width channel 6 reaches the top secondary positions 5, 13 and 21, and `ber_chan` spans values up to 6. Channel 1's branch bit 16, which a secondary clear cannot reach, is also in range, and so is the underrun of channel 1, which is masked from control C. A behavioural model follows every edge, including random control writes that toggle enable and the disable request.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;
  localparam int ID_W   = 32;

  localparam logic [ADDR_W-1:0] A_CTLA = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTLB = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTLC = 3'd2;
  localparam logic [ADDR_W-1:0] A_STP  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STS  = 3'd4;
  localparam logic [ADDR_W-1:0] A_IDC  = 3'd5;

  localparam logic [REG_W-1:0] CTLA_WMASK = 32'h07FF_FFFF;
  localparam logic [REG_W-1:0] CTLB_WMASK = 32'hEFFF_FFFF;
  localparam logic [REG_W-1:0] CTLC_WMASK = 32'h3F3F_3F3F;
  localparam logic [REG_W-1:0] STS_CMASK  = 32'h003E_3F3F;

  // primary status bit positions
  localparam int P_LFD  = 0;
  localparam int P_SOF  = 1;
  localparam int P_BER  = 2;
  localparam int P_ACB  = 3;
  localparam int P_UD0  = 4;
  localparam int P_UD1  = 5;
  localparam int P_OUF  = 6;
  localparam int P_QDS  = 7;
  localparam int P_EOF  = 8;
  localparam int P_BRS  = 9;
  localparam int P_SUM  = 10;
  localparam int P_RDS  = 11;
  localparam int P_CMD  = 12;
  localparam int P_CHLO = 28;

  // control A bit positions
  localparam int C_EN   = 0;
  localparam int C_MLFD = 3;
  localparam int C_MSOF = 4;
  localparam int C_MUD0 = 5;
  localparam int C_MEOF = 6;
  localparam int C_DREQ = 10;
  localparam int C_MQDS = 11;
  localparam int C_MBRS = 20;
  localparam int C_MOUF = 21;
  localparam int C_NOAB = 22;
  localparam int C_MRDS = 23;
  localparam int C_MCMD = 24;
  localparam int C_MUD1 = 24; // in control C

  // secondary status offsets
  localparam int S_SOF = -1;
  localparam int S_EOF = 7;
  localparam int S_BRS = 15;
endpackage

// File: rtl/disp_ctl_regs.sv
module disp_ctl_regs
  import disp_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             frame_end,
  output logic [REG_W-1:0] ctla,
  output logic [REG_W-1:0] ctlb,
  output logic [REG_W-1:0] ctlc,
  output logic             qds_set,
  output logic             acb_set,
  output logic             lfd_set
);
  logic wa, wb, wc;
  assign wa = wr_en && (wr_addr == A_CTLA);
  assign wb = wr_en && (wr_addr == A_CTLB);
  assign wc = wr_en && (wr_addr == A_CTLC);

  assign qds_set = wa && ctla[C_EN] && !wr_data[C_EN];
  assign acb_set = wa && (|ctlb[19:16]) && wr_data[C_EN] && !wr_data[C_NOAB];
  assign lfd_set = frame_end && ctla[C_EN] && ctla[C_DREQ];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctla <= '0;
      ctlb <= '0;
      ctlc <= '0;
    end else begin
      if (wa)           ctla <= wr_data & CTLA_WMASK;
      else if (lfd_set) ctla[C_EN] <= 1'b0;
      if (wb) ctlb <= wr_data & CTLB_WMASK;
      if (wc) ctlc <= wr_data & CTLC_WMASK;
    end
  end

  // R11: a disable request at frame end turns the controller off
  p_lfd_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && ctla[C_EN] && ctla[C_DREQ] && !wa) |=> !ctla[C_EN]);

  // R13: control C never holds bits outside its write mask after a write
  p_ctlc_mask_r13: assert property (@(posedge clk) disable iff (!rst_n)
    wc |=> ((ctlc & ~CTLC_WMASK) == '0));
endmodule

// File: rtl/disp_evt_route.sv
module disp_evt_route
  import disp_irq_pkg::*;
#(
  parameter int NCH = 7
) (
  input  logic [NCH-1:0]      sof_pulse,
  input  logic [NCH-1:0]      sof_en,
  input  logic [NCH-1:0]      eof_pulse,
  input  logic [NCH-1:0]      eof_en,
  input  logic [NCH-1:0]      brs_pulse,
  input  logic [1:0]          udr_pulse,
  input  logic                ouf_pulse,
  input  logic                rdst_pulse,
  input  logic                cmd_pulse,
  input  logic                ber_pulse,
  input  logic [2:0]          ber_chan,
  input  logic [NCH*ID_W-1:0] frame_ids,
  input  logic [REG_W-1:0]    ctla,
  input  logic [REG_W-1:0]    ctlc,
  output logic [REG_W-1:0]    set_p,
  output logic [REG_W-1:0]    set_s,
  output logic                id_we,
  output logic [ID_W-1:0]     id_val
);
  logic [NCH-1:0]  sof_a, eof_a, hit;
  logic [ID_W-1:0] fid [NCH];

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_fid
      assign fid[g] = frame_ids[g*ID_W +: ID_W];
    end
  endgenerate

  assign sof_a = sof_pulse & sof_en;
  assign eof_a = eof_pulse & eof_en;

  always_comb begin
    set_p = '0;
    set_s = '0;
    set_p[P_SOF] = sof_a[0];
    set_p[P_EOF] = eof_a[0];
    set_p[P_BRS] = brs_pulse[0];
    set_p[P_UD0] = udr_pulse[0];
    set_p[P_UD1] = udr_pulse[1];
    set_p[P_OUF] = ouf_pulse;
    set_p[P_RDS] = rdst_pulse;
    set_p[P_CMD] = cmd_pulse;
    set_p[P_BER] = ber_pulse;
    hit = '0;
    hit[0] = (sof_a[0] && !ctla[C_MSOF]) || (eof_a[0] && !ctla[C_MEOF]) ||
             (brs_pulse[0] && !ctla[C_MBRS]);
    for (int c = 1; c < NCH; c++) begin
      set_s[c + S_SOF] = sof_a[c];
      set_s[c + S_EOF] = eof_a[c];
      set_s[c + S_BRS] = brs_pulse[c];
      hit[c] = (sof_a[c] && !ctlc[c + S_SOF]) || (eof_a[c] && !ctlc[c + S_EOF]) ||
               (brs_pulse[c] && !ctlc[c + S_BRS]);
    end
    id_we = ber_pulse || (|hit);
    set_p[P_SUM] = id_we;
    id_val = '0;
    for (int c = 0; c < NCH; c++)
      if (hit[c]) id_val = fid[c];
    if (ber_pulse) begin
      id_val = '0;
      for (int c = 0; c < NCH; c++)
        if (ber_chan == 3'(c)) id_val = fid[c];
    end
  end
endmodule

// File: rtl/disp_irq_merge.sv
module disp_irq_merge
  import disp_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] stat_p,
  input  logic [REG_W-1:0] stat_s,
  input  logic [REG_W-1:0] ctla,
  input  logic [REG_W-1:0] ctlc,
  output logic             irq
);
  logic [REG_W-1:0] live_p;
  logic             irq_d;

  always_comb begin
    live_p = '0;
    live_p[P_LFD] = !ctla[C_MLFD];
    live_p[P_SOF] = !ctla[C_MSOF];
    live_p[P_UD0] = !ctla[C_MUD0];
    live_p[P_UD1] = !ctlc[C_MUD1];
    live_p[P_OUF] = !ctla[C_MOUF];
    live_p[P_QDS] = !ctla[C_MQDS];
    live_p[P_EOF] = !ctla[C_MEOF];
    live_p[P_BRS] = !ctla[C_MBRS];
    live_p[P_RDS] = !ctla[C_MRDS];
    live_p[P_CMD] = !ctla[C_MCMD];
    irq_d = (|(stat_p & live_p)) || (|(stat_s & ~ctlc));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  // R7: unmasked secondary status raises the line one edge later
  p_sec_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_s & ~ctlc)) |=> irq);

  // R7: bus error, AC-bias and summary alone never raise the line
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (((stat_p & ~32'h7000_040C) == '0) && (stat_s == '0)) |=> !irq);
endmodule

// File: rtl/disp_irq_status.sv
module disp_irq_status
  import disp_irq_pkg::*;
#(
  parameter int NCH = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2:0]          wr_addr,
  input  logic [31:0]         wr_data,
  input  logic [2:0]          rd_addr,
  output logic [31:0]         rd_data,
  input  logic [NCH-1:0]      sof_pulse,
  input  logic [NCH-1:0]      sof_en,
  input  logic [NCH-1:0]      eof_pulse,
  input  logic [NCH-1:0]      eof_en,
  input  logic [NCH-1:0]      brs_pulse,
  input  logic [1:0]          udr_pulse,
  input  logic                ouf_pulse,
  input  logic                rdst_pulse,
  input  logic                cmd_pulse,
  input  logic                ber_pulse,
  input  logic [2:0]          ber_chan,
  input  logic                frame_end,
  input  logic [NCH*32-1:0]   frame_ids,
  output logic                irq
);
  logic [REG_W-1:0] ctla, ctlb, ctlc;
  logic [REG_W-1:0] stat_p, stat_s;
  logic [ID_W-1:0]  id_cap;
  logic [REG_W-1:0] set_p, set_s, clr_p, clr_s, nxt_p;
  logic             qds_set, acb_set, lfd_set, id_we;
  logic [ID_W-1:0]  id_val;
  logic             wsp, wss;

  disp_ctl_regs u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_end(frame_end), .ctla(ctla), .ctlb(ctlb),
    .ctlc(ctlc), .qds_set(qds_set), .acb_set(acb_set), .lfd_set(lfd_set)
  );

  disp_evt_route #(.NCH(NCH)) u_route (
    .sof_pulse(sof_pulse), .sof_en(sof_en), .eof_pulse(eof_pulse),
    .eof_en(eof_en), .brs_pulse(brs_pulse), .udr_pulse(udr_pulse),
    .ouf_pulse(ouf_pulse), .rdst_pulse(rdst_pulse), .cmd_pulse(cmd_pulse),
    .ber_pulse(ber_pulse), .ber_chan(ber_chan), .frame_ids(frame_ids),
    .ctla(ctla), .ctlc(ctlc), .set_p(set_p), .set_s(set_s),
    .id_we(id_we), .id_val(id_val)
  );

  disp_irq_merge u_merge (
    .clk(clk), .rst_n(rst_n), .stat_p(stat_p), .stat_s(stat_s),
    .ctla(ctla), .ctlc(ctlc), .irq(irq)
  );

  assign wsp = wr_en && (wr_addr == A_STP);
  assign wss = wr_en && (wr_addr == A_STS);

  always_comb begin
    clr_p = '0;
    if (wsp) begin
      clr_p[11:0] = wr_data[11:0];
      clr_p[P_CHLO +: 3] = {3{wr_data[P_BER]}};
    end
    clr_s = wss ? (wr_data & STS_CMASK) : '0;
    nxt_p = (stat_p & ~clr_p) | set_p;
    nxt_p[P_QDS] = nxt_p[P_QDS] | qds_set;
    nxt_p[P_ACB] = nxt_p[P_ACB] | acb_set;
    nxt_p[P_LFD] = nxt_p[P_LFD] | lfd_set;
    if (ber_pulse) nxt_p[P_CHLO +: 3] = ber_chan;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_p <= '0;
      stat_s <= '0;
      id_cap <= '0;
    end else begin
      stat_p <= nxt_p;
      stat_s <= (stat_s & ~clr_s) | set_s;
      if (id_we) id_cap <= id_val;
    end
  end

  always_comb begin
    unique case (rd_addr)
      A_CTLA:  rd_data = ctla;
      A_CTLB:  rd_data = ctlb;
      A_CTLC:  rd_data = ctlc;
      A_STP:   rd_data = stat_p;
      A_STS:   rd_data = stat_s;
      A_IDC:   rd_data = id_cap;
      default: rd_data = '0;
    endcase
  end

  // R6: a bus error leaves its flag, the summary and the channel number
  p_ber_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ber_pulse |=> (stat_p[P_BER] && stat_p[P_SUM] && stat_p[30:28] == $past(ber_chan)));

  // R9: an event beats a clear on the same edge
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdst_pulse && wsp && wr_data[P_RDS]) |=> stat_p[P_RDS]);

  // R10: dropping the enable raises the quick-disable flag
  p_qds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTLA && ctla[C_EN] && !wr_data[C_EN]) |=> stat_p[P_QDS]);

  // R11: a disable request at frame end raises the last-frame flag
  p_lfd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && ctla[C_EN] && ctla[C_DREQ]) |=> stat_p[P_LFD]);

  // R4: a disabled start-of-frame alone leaves secondary status unchanged
  p_sof_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((sof_pulse & ~sof_en) != '0 && (sof_pulse & sof_en) == '0 && eof_pulse == '0 &&
     brs_pulse == '0 && !wss) |=> $stable(stat_s));
endmodule

// File: tb/disp_irq_status_tb.sv
module disp_irq_status_tb;
  localparam int NCH = 7;
  localparam time TCK = 10ns;
  localparam int WDOG = 20000;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0, ber_chan = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [NCH-1:0] sof_pulse = 0, sof_en = 0, eof_pulse = 0, eof_en = 0, brs_pulse = 0;
  logic [1:0] udr_pulse = 0;
  logic ouf_pulse = 0, rdst_pulse = 0, cmd_pulse = 0, ber_pulse = 0, frame_end = 0;
  logic [NCH*32-1:0] frame_ids;
  logic irq;

  int total = 0, bad = 0, cycles = 0;

  always #(TCK/2) clk = ~clk;

  disp_irq_status #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sof_pulse(sof_pulse), .sof_en(sof_en),
    .eof_pulse(eof_pulse), .eof_en(eof_en), .brs_pulse(brs_pulse),
    .udr_pulse(udr_pulse), .ouf_pulse(ouf_pulse), .rdst_pulse(rdst_pulse),
    .cmd_pulse(cmd_pulse), .ber_pulse(ber_pulse), .ber_chan(ber_chan),
    .frame_end(frame_end), .frame_ids(frame_ids), .irq(irq)
  );

  // ---------------- reference model ----------------
  bit [31:0] m_reg [6];
  bit        m_irq;

  function automatic bit [31:0] fid(int c);
    return frame_ids[c*32 +: 32];
  endfunction

  always @(posedge clk) begin
    bit [31:0] a, b, cc, p, s, idc;
    bit hitany;
    int pm [10][2];
    a = m_reg[0]; b = m_reg[1]; cc = m_reg[2]; p = m_reg[3]; s = m_reg[4]; idc = m_reg[5];
    if (!rst_n) begin
      foreach (m_reg[i]) m_reg[i] = 0;
      m_irq = 0;
    end else begin
      // interrupt from the state before this edge: {status bit, mask bit (+100 = control C)}
      pm = '{'{0,3},'{1,4},'{4,5},'{5,124},'{6,21},'{7,11},'{8,6},'{9,20},'{11,23},'{12,24}};
      m_irq = (s & ~cc) != 0;
      foreach (pm[i]) begin
        bit mk;
        mk = (pm[i][1] >= 100) ? cc[pm[i][1]-100] : a[pm[i][1]];
        if (p[pm[i][0]] && !mk) m_irq = 1;
      end
      // software clears
      if (wr_en && wr_addr == 3) begin
        p = p & ~{20'h0, wr_data[11:0]};
        if (wr_data[2]) p[30:28] = 0;
      end
      if (wr_en && wr_addr == 4) s = s & ~(wr_data & 32'h003E3F3F);
      // events
      hitany = 0;
      for (int c = 0; c < NCH; c++) begin
        bit sa, ea, ba, h;
        sa = sof_pulse[c] && sof_en[c];
        ea = eof_pulse[c] && eof_en[c];
        ba = brs_pulse[c];
        if (c == 0) begin
          if (sa) p[1] = 1;
          if (ea) p[8] = 1;
          if (ba) p[9] = 1;
          h = (sa && !a[4]) || (ea && !a[6]) || (ba && !a[20]);
        end else begin
          if (sa) s[c-1] = 1;
          if (ea) s[c+7] = 1;
          if (ba) s[c+15] = 1;
          h = (sa && !cc[c-1]) || (ea && !cc[c+7]) || (ba && !cc[c+15]);
        end
        if (h) begin idc = fid(c); hitany = 1; end
      end
      if (udr_pulse[0]) p[4] = 1;
      if (udr_pulse[1]) p[5] = 1;
      if (ouf_pulse) p[6] = 1;
      if (rdst_pulse) p[11] = 1;
      if (cmd_pulse) p[12] = 1;
      if (ber_pulse) begin
        p[2] = 1; p[30:28] = ber_chan; hitany = 1;
        idc = (ber_chan < NCH) ? fid(int'(ber_chan)) : 0;
      end
      if (hitany) p[10] = 1;
      // control writes and handshakes
      if (frame_end && a[0] && a[10]) begin p[0] = 1; m_reg[0][0] = 0; end
      if (wr_en && wr_addr == 0) begin
        if (a[0] && !wr_data[0]) p[7] = 1;
        if (b[19:16] != 0 && wr_data[0] && !wr_data[22]) p[3] = 1;
        m_reg[0] = wr_data & 32'h07FFFFFF;
      end
      if (wr_en && wr_addr == 1) m_reg[1] = wr_data & 32'hEFFFFFFF;
      if (wr_en && wr_addr == 2) m_reg[2] = wr_data & 32'h3F3F3F3F;
      m_reg[3] = p; m_reg[4] = s; m_reg[5] = idc;
    end
  end

  // ---------------- checks ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      string t;
      cycles++;
      chk("R7 irq vs model", {31'h0, irq}, {31'h0, m_irq});
      case (rd_addr)
        0, 1, 2: t = "R13 control vs model";
        3: t = "R2 primary vs model";
        4: t = "R3 secondary vs model";
        5: t = "R5 capture vs model";
        default: t = "R1 unused address vs model";
      endcase
      chk(t, rd_data, (rd_addr < 6) ? m_reg[rd_addr] : 32'h0);
    end
  end

  initial begin
    #(TCK * WDOG);
    bad++; total++;
    $display("FAIL R1 watchdog actual=%0d expected<%0d", cycles, WDOG);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
    wr_en = 0; sof_pulse = 0; eof_pulse = 0; brs_pulse = 0; udr_pulse = 0;
    ouf_pulse = 0; rdst_pulse = 0; cmd_pulse = 0; ber_pulse = 0; frame_end = 0;
  endtask

  task automatic wr(logic [2:0] ad, logic [31:0] d);
    wr_en = 1; wr_addr = ad; wr_data = d;
    step();
  endtask

  task automatic rd(logic [2:0] ad, output logic [31:0] v);
    rd_addr = ad;
    #1;
    v = rd_data;
  endtask

  initial begin
    logic [31:0] v;
    for (int c = 0; c < NCH; c++) frame_ids[c*32 +: 32] = 32'hA500_0000 + 32'(c * 32'h111);
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    for (int ad = 0; ad < 7; ad++) begin
      rd(3'(ad), v);
      chk("R1 reset value", v, 0);
    end
    chk("R1 irq after reset", {31'h0, irq}, 0);

    // R13 masks and R10 quick disable
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); chk("R13 control A mask", v, 32'h07FF_FFFF);
    wr(0, 32'h0);
    rd(3, v); chk("R10 quick-disable flag", v & 32'h80, 32'h80);
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); chk("R13 control B mask", v, 32'hEFFF_FFFF);
    wr(2, 32'hFFFF_FFFF);
    rd(2, v); chk("R13 control C mask", v, 32'h3F3F_3F3F);
    // R12 AC-bias
    wr(0, 32'h1);
    rd(3, v); chk("R12 AC-bias flag", v & 32'h8, 32'h8);
    step();
    chk("R7 irq from unmasked quick-disable", {31'h0, irq}, 1);
    // R8 clear primary
    wr(3, 32'h0000_0FFF);
    rd(3, v); chk("R8 primary cleared", v, 0);
    step();
    chk("R7 irq drops after clear", {31'h0, irq}, 0);

    // R4 disabled start-of-frame
    sof_pulse = 7'h01; sof_en = 0; step();
    rd(3, v); chk("R4 disabled SOF ignored", v, 0);
    rd(5, v); chk("R4 disabled SOF leaves capture", v, 0);
    // R2 / R5 channel 0 start-of-frame
    sof_en = '1; eof_en = '1;
    sof_pulse = 7'h01; step();
    rd(3, v); chk("R2 SOF ch0 bit 1 and summary", v, 32'h402);
    rd(5, v); chk("R5 capture ch0", v, 32'hA500_0000);
    wr(3, 32'hFFF);
    // R5 masked channel 3 (control C all set)
    eof_pulse = 7'h08; step();
    rd(4, v); chk("R3 EOF ch3 at bit 10", v, 32'h400);
    rd(3, v); chk("R5 masked event no summary", v, 0);
    rd(5, v); chk("R5 masked event keeps capture", v, 32'hA500_0000);
    wr(2, 0);
    sof_pulse = 7'h08; step();
    rd(4, v); chk("R3 SOF ch3 at bit 2", v, 32'h404);
    rd(5, v); chk("R5 capture ch3", v, 32'hA500_0333);
    // R5 priority
    sof_pulse = 7'h14; step();
    rd(5, v); chk("R5 highest channel wins", v, 32'hA500_0444);
    // R6 bus error wins over ch6
    ber_pulse = 1; ber_chan = 5; brs_pulse = 7'h40; step();
    rd(3, v); chk("R6 bus error flags and channel", v, 32'h5000_0404);
    rd(5, v); chk("R6 bus error capture", v, 32'hA500_0555);
    rd(4, v); chk("R3 branch ch6 at bit 21", v & 32'h0020_0000, 32'h0020_0000);
    wr(3, 32'h4);
    rd(3, v); chk("R8 bit 2 clears channel field", v, 32'h400);
    // R9 set beats clear
    rdst_pulse = 1; wr(3, 32'hFFF);
    rd(3, v); chk("R9 event beats clear", v, 32'h800);
    // R8 secondary clear mask
    brs_pulse = 7'h02; step();
    wr(4, 32'hFFFF_FFFF);
    rd(4, v); chk("R8 secondary clear mask", v, 32'h0001_0000);
    // R2 remaining controller-wide bits
    wr(3, 32'hFFF);
    udr_pulse = 2'b11; ouf_pulse = 1; cmd_pulse = 1; step();
    rd(3, v); chk("R2 underrun, output underrun, command", v, 32'h1070);
    // R11 disable request at frame end
    wr(1, 0);
    wr(0, 32'h401);
    frame_end = 1; step();
    rd(0, v); chk("R11 enable cleared", v, 32'h400);
    rd(3, v); chk("R11 last-frame flag", v & 32'h1, 32'h1);

    // random phase against the model
    for (int i = 0; i < 600; i++) begin
      int k;
      k = $urandom_range(0, 9);
      sof_pulse = 7'($urandom); eof_pulse = 7'($urandom); brs_pulse = 7'($urandom);
      sof_en = 7'($urandom); eof_en = 7'($urandom);
      udr_pulse = 2'($urandom); ouf_pulse = ($urandom_range(0, 7) == 0);
      rdst_pulse = ($urandom_range(0, 7) == 0); cmd_pulse = ($urandom_range(0, 7) == 0);
      ber_pulse = ($urandom_range(0, 9) == 0); ber_chan = 3'($urandom_range(0, NCH - 1));
      frame_end = ($urandom_range(0, 3) == 0);
      if (i % 50 == 0) frame_ids[($urandom_range(0, NCH - 1))*32 +: 32] = $urandom;
      rd_addr = 3'($urandom_range(0, 6));
      if (k < 5) begin
        wr_en = 1; wr_addr = 3'($urandom_range(0, 4)); wr_data = $urandom;
      end
      step();
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule